// File: doc/BRIEF.md
# Flash Byte-Program Status Generator

This block is the device side of a small embedded flash array during a single-byte program operation. A write request that has already been decoded arrives with a byte address and data. The block accepts it only when the target sector is selected and not write-protected. It then runs a program interval measured in clock cycles. During that interval an active-low ready/busy pin is held low. Any read of the target byte returns a status byte in place of the array contents, so software can poll for completion.

The status byte carries the following fields. Bit 7 is the inverse of bit 7 of the intended data until the byte is written. Bit 6 flips on every status read. Bit 5 is an error flag, and bit 3 is an erase-timer flag that this block always drives to 0. Bits 4, 2, 1 and 0 are driven to 0, and software must treat them as undefined. An internal timer that expires before the program interval ends aborts the operation with an error. A request that tries to raise a 0 bit back to 1 still writes `old & new`, then finishes with the error flag set. After an error, the block keeps returning status until the error-clear input is pulsed.

The cell array is built from registers, so the block can be tested alone. It erases to 0xFF on reset and is readable at any time. Reads have one cycle of latency.

Top module: `flash_prog_status`

## Requirements
- R1: A request whose sector has its protect bit set is dropped. No operation starts, `busy_n` stays 1 and the target byte is unchanged. The sector is the top `SECT_W` bits of the address, so addresses 4..7 are sector 1 by default.
- R2: A request whose sector chip-select bit is 0 is dropped in the same way.
- R3: An accepted request drives `busy_n` low for exactly `PROG_CYC` cycles, counted from the edge that accepts it. Requests that arrive while an operation or an error is pending are dropped.
- R4: During the program interval, a read of the target address returns bit 7 equal to the inverse of bit 7 of the intended data.
- R5: On normal completion the target byte becomes `old & new`. A later read returns it, so bit 7 then matches the intended bit 7.
- R6: If `TMO_CYC` cycles elapse before `PROG_CYC`, the operation ends early and the array is left unchanged. `busy_n` goes high after `TMO_CYC` cycles, and target reads return bit 5 = 1 with bit 7 inverted.
- R7: If the new data has a 1 where the stored byte has a 0, the byte is still written as `old & new`. The operation then ends in the error state, with bit 5 = 1 on target reads.
- R8: Bit 6 of the status byte inverts between consecutive status reads. Once the block is idle, reads of the same byte return identical values.
- R9: During a normal program interval, status bits 5 and 3 read 0.
- R10: Reads of addresses other than the target return array contents, even while an operation or error is pending.
- R11: A `clr_err` pulse in the error state returns the block to plain array reads. In any other state the pulse has no effect.
- R12: After reset the array holds 0xFF in every byte, `busy_n` is 1 and `rd_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_req | input | 1 | One-cycle program request |
| prog_addr | input | ADDR_W | Byte address to program |
| prog_data | input | 8 | Data to program |
| sect_cs | input | 2**SECT_W | Per-sector chip-select |
| sect_prot | input | 2**SECT_W | Per-sector write protect |
| clr_err | input | 1 | Error-clear command |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Registered read data or status byte |
| busy_n | output | 1 | Low while the program interval runs |

## Verification
Two events can fall in the same cycle: a status read of the target and the end of the program interval. A read issued on the edge that finishes the operation must still see the pre-edge state. The bench provokes this by polling the target back to back until `busy_n` rises, then judges the read taken one cycle after the rise against the array value. A second overlap pairs the internal timer with the program counter. A separately parameterised instance with a shorter timeout shares the stimulus, and the bench judges from its early `busy_n` rise and its untouched cell that the timeout took priority.

// File: rtl/fps_pkg.sv
// Package: shared state encoding for the flash program status block.
package fps_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PROG = 2'd1,
        ST_ERR  = 2'd2
    } fps_state_e;
endpackage

// File: rtl/fps_array.sv
// Module: fps_array
// Behavioural register cell array. A write can only clear bits (stored byte
// is ANDed with write data). Two asynchronous read ports.
// Assumes: synchronous active-low reset erases every byte to 0xFF.
module fps_array #(
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr_a,
    output logic [7:0]        rd_byte_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic [7:0]        rd_byte_b
);
    logic [7:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        // Per-byte cell: erase on reset, clear-only programming.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[g] <= 8'hFF;
            else if (wr_en && wr_addr == ADDR_W'(g))
                mem[g] <= mem[g] & wr_data;
        end
    end

    // Read ports: plain combinational lookup.
    assign rd_byte_a = mem[rd_addr_a];
    assign rd_byte_b = mem[rd_addr_b];
endmodule

// File: rtl/fps_ctrl.sv
// Module: fps_ctrl
// Accepts one program request, runs the program-duration and timeout
// counters, and decides between normal completion and the error state.
// Assumes: old_byte is the current array content at prog_addr.
module fps_ctrl
    import fps_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int SECT_W   = 2,
    parameter int PROG_CYC = 8,
    parameter int TMO_CYC  = 20,
    localparam int N_SECT  = 1 << SECT_W,
    localparam int CNT_MAX = (PROG_CYC > TMO_CYC) ? PROG_CYC : TMO_CYC,
    localparam int CNT_W   = $clog2(CNT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_req,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [7:0]        prog_data,
    input  logic [N_SECT-1:0] sect_cs,
    input  logic [N_SECT-1:0] sect_prot,
    input  logic              clr_err,
    input  logic [7:0]        old_byte,
    output fps_state_e        state,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [7:0]        tgt_data,
    output logic              wr_en
);
    logic [SECT_W-1:0] sect;
    logic              accept;
    logic [CNT_W-1:0]  cnt;
    logic              tmo_hit;
    logic              done_hit;
    logic              illegal;

    // Request qualification: idle, sector selected and not protected.
    assign sect   = prog_addr[ADDR_W-1 -: SECT_W];
    assign accept = prog_req && (state == ST_IDLE) && sect_cs[sect] && !sect_prot[sect];

    // Counter limits; timeout has priority when both hit together.
    assign tmo_hit  = (cnt == CNT_W'(TMO_CYC - 1));
    assign done_hit = (cnt == CNT_W'(PROG_CYC - 1));
    assign wr_en    = (state == ST_PROG) && done_hit && !tmo_hit;

    // Operation sequencer and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            tgt_addr <= '0;
            tgt_data <= '0;
            illegal  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state    <= ST_PROG;
                        cnt      <= '0;
                        tgt_addr <= prog_addr;
                        tgt_data <= prog_data;
                        illegal  <= |(~old_byte & prog_data);
                    end
                end
                ST_PROG: begin
                    if (tmo_hit)
                        state <= ST_ERR;
                    else if (done_hit)
                        state <= illegal ? ST_ERR : ST_IDLE;
                    else
                        cnt <= cnt + 1'b1;
                end
                ST_ERR: begin
                    if (clr_err)
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fps_status.sv
// Module: fps_status
// Registered read path: returns the status byte for reads of the target
// while an operation or error is pending, array data otherwise.
// Assumes: arr_byte is the array content at rd_addr.
module fps_status
    import fps_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  fps_state_e        state,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic              tgt_d7,
    input  logic [7:0]        arr_byte,
    output logic [7:0]        rd_data
);
    logic       tog;
    logic       stat_hit;
    logic [7:0] stat_byte;

    // Status selection and byte assembly (undefined bits driven 0).
    assign stat_hit  = rd_en && (state != ST_IDLE) && (rd_addr == tgt_addr);
    assign stat_byte = {~tgt_d7, tog, (state == ST_ERR), 1'b0, 1'b0, 3'b000};

    // Read data register and toggle flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= 8'h00;
            tog     <= 1'b0;
        end else if (rd_en) begin
            rd_data <= stat_hit ? stat_byte : arr_byte;
            if (stat_hit)
                tog <= ~tog;
        end
    end
endmodule

// File: rtl/flash_prog_status.sv
// Module: flash_prog_status (top)
// Single-byte flash program engine with polled status and ready/busy pin.
// Assumes: prog_req is already decoded from the command sequence.
module flash_prog_status
    import fps_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int SECT_W   = 2,
    parameter int PROG_CYC = 8,
    parameter int TMO_CYC  = 20,
    localparam int N_SECT  = 1 << SECT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_req,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [7:0]        prog_data,
    input  logic [N_SECT-1:0] sect_cs,
    input  logic [N_SECT-1:0] sect_prot,
    input  logic              clr_err,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy_n
);
    fps_state_e        state;
    logic [ADDR_W-1:0] tgt_addr;
    logic [7:0]        tgt_data;
    logic              wr_en;
    logic [7:0]        old_byte;
    logic [7:0]        arr_byte;

    fps_ctrl #(
        .ADDR_W(ADDR_W), .SECT_W(SECT_W),
        .PROG_CYC(PROG_CYC), .TMO_CYC(TMO_CYC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .prog_req(prog_req),
        .prog_addr(prog_addr), .prog_data(prog_data),
        .sect_cs(sect_cs), .sect_prot(sect_prot), .clr_err(clr_err),
        .old_byte(old_byte), .state(state), .tgt_addr(tgt_addr),
        .tgt_data(tgt_data), .wr_en(wr_en)
    );

    fps_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(tgt_addr),
        .wr_data(tgt_data), .rd_addr_a(prog_addr), .rd_byte_a(old_byte),
        .rd_addr_b(rd_addr), .rd_byte_b(arr_byte)
    );

    fps_status #(.ADDR_W(ADDR_W)) u_status (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .state(state), .tgt_addr(tgt_addr), .tgt_d7(tgt_data[7]),
        .arr_byte(arr_byte), .rd_data(rd_data)
    );

    // Ready/busy pin: low only during the program interval.
    assign busy_n = (state != ST_PROG);
endmodule

// File: rtl/fps_checker.sv
// Module: fps_checker
// Protocol assertions for flash_prog_status, attached with bind below.
module fps_checker
    import fps_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int SECT_W = 2,
    localparam int N_SECT = 1 << SECT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              prog_req,
    input logic [ADDR_W-1:0] prog_addr,
    input logic [N_SECT-1:0] sect_cs,
    input logic [N_SECT-1:0] sect_prot,
    input logic              clr_err,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              poll_bit,
    input logic              err_bit,
    input logic              busy_n,
    input fps_state_e        state,
    input logic [ADDR_W-1:0] tgt_addr,
    input logic              tgt_d7
);
    logic [SECT_W-1:0] sect;
    assign sect = prog_addr[ADDR_W-1 -: SECT_W];

    AST_PROT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req && state == ST_IDLE && sect_prot[sect]) |=> (busy_n && state == ST_IDLE)); // R1
    AST_CS_REQUIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req && state == ST_IDLE && !sect_cs[sect]) |=> busy_n); // R2
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req && state == ST_IDLE && sect_cs[sect] && !sect_prot[sect]) |=> !busy_n); // R3
    AST_POLL_INVERTED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && state != ST_IDLE && rd_addr == tgt_addr) |=> (poll_bit == !$past(tgt_d7))); // R4
    AST_ERR_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && state == ST_ERR && rd_addr == tgt_addr) |=> err_bit); // R6
    AST_CLEAR_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERR && clr_err) |=> (state == ST_IDLE && busy_n)); // R11
endmodule

bind flash_prog_status fps_checker #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .prog_addr(prog_addr),
    .sect_cs(sect_cs), .sect_prot(sect_prot), .clr_err(clr_err),
    .rd_en(rd_en), .rd_addr(rd_addr), .poll_bit(rd_data[7]),
    .err_bit(rd_data[5]), .busy_n(busy_n), .state(state),
    .tgt_addr(tgt_addr), .tgt_d7(tgt_data[7])
);

// File: tb/tb_flash_prog_status.sv
// Directed bench: one task per scenario. A second instance with a short
// timeout shares the stimulus to exercise the timeout path.
module tb_flash_prog_status;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 4;
    localparam int SECT_W = 2;
    localparam int N_SECT = 1 << SECT_W;
    localparam int PROG_CYC = 8;
    localparam int TMO_LONG = 20;
    localparam int TMO_SHORT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prog_req = 1'b0;
    logic [ADDR_W-1:0] prog_addr = '0;
    logic [7:0] prog_data = '0;
    logic [N_SECT-1:0] sect_cs = '1;
    logic [N_SECT-1:0] sect_prot = '0;
    logic clr_err = 1'b0;
    logic rd_en = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [7:0] rd_data, rd_data_to;
    logic busy_n, busy_n_to;

    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_prog_status #(.ADDR_W(ADDR_W), .SECT_W(SECT_W),
        .PROG_CYC(PROG_CYC), .TMO_CYC(TMO_LONG)) dut (
        .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .prog_addr(prog_addr),
        .prog_data(prog_data), .sect_cs(sect_cs), .sect_prot(sect_prot),
        .clr_err(clr_err), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy_n(busy_n));

    flash_prog_status #(.ADDR_W(ADDR_W), .SECT_W(SECT_W),
        .PROG_CYC(PROG_CYC), .TMO_CYC(TMO_SHORT)) dut_to (
        .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .prog_addr(prog_addr),
        .prog_data(prog_data), .sect_cs(sect_cs), .sect_prot(sect_prot),
        .clr_err(clr_err), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data_to), .busy_n(busy_n_to));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_req(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        prog_addr = a; prog_data = d; prog_req = 1'b1;
        @(negedge clk);
        prog_req = 1'b0;
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a, output logic [7:0] v, output logic [7:0] v_to);
        rd_addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data; v_to = rd_data_to;
    endtask

    task automatic pulse_clr();
        clr_err = 1'b1;
        @(negedge clk);
        clr_err = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100 && !busy_n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v, vt;
        chk(busy_n == 1'b1, "R12 busy_n after reset", busy_n, 1);
        chk(rd_data == 8'h00, "R12 rd_data after reset", rd_data, 0);
        do_read(4'd0, v, vt);
        chk(v == 8'hFF, "R12 erased byte", v, 8'hFF);
    endtask

    task automatic t_protect();
        logic [7:0] v, vt;
        sect_prot = 4'b0010;
        do_req(4'd5, 8'h00);
        chk(busy_n == 1'b1, "R1 protected request no busy", busy_n, 1);
        sect_prot = '0;
        do_read(4'd5, v, vt);
        chk(v == 8'hFF, "R1 protected byte unchanged", v, 8'hFF);
    endtask

    task automatic t_chipsel();
        logic [7:0] v, vt;
        sect_cs = 4'b1101;
        do_req(4'd6, 8'h00);
        chk(busy_n == 1'b1, "R2 deselected request no busy", busy_n, 1);
        sect_cs = '1;
        do_read(4'd6, v, vt);
        chk(v == 8'hFF, "R2 deselected byte unchanged", v, 8'hFF);
    endtask

    task automatic t_busy_len();
        logic [7:0] v, vt;
        int n;
        do_req(4'd1, 8'h5A);
        chk(busy_n == 1'b0, "R3 busy after accept", busy_n, 0);
        do_req(4'd2, 8'h00);
        n = 1;
        while (!busy_n && n < 100) begin n++; @(negedge clk); end
        chk(n == PROG_CYC, "R3 busy length", n, PROG_CYC);
        do_read(4'd2, v, vt);
        chk(v == 8'hFF, "R3 request while busy dropped", v, 8'hFF);
        do_read(4'd1, v, vt);
        chk(v == 8'h5A, "R5 programmed byte", v, 8'h5A);
    endtask

    task automatic t_status();
        logic [7:0] s1, s2, v, vt, w;
        do_req(4'd8, 8'h3C);
        do_read(4'd8, s1, vt);
        chk(s1[7] == 1'b1, "R4 poll bit inverted", s1[7], 1);
        chk(s1[5] == 1'b0 && s1[3] == 1'b0, "R9 bits 5 and 3 clear", s1 & 8'h28, 0);
        do_read(4'd8, s2, vt);
        chk(s2[6] != s1[6], "R8 toggle flips", s2[6], !s1[6]);
        do_read(4'd1, v, vt);
        chk(v == 8'h5A, "R10 other address during program", v, 8'h5A);
        while (!busy_n) do_read(4'd8, v, vt);
        do_read(4'd8, v, vt);
        chk(v == 8'h3C, "R5 read after completion", v, 8'h3C);
        do_read(4'd8, w, vt);
        chk(w == v, "R8 steady when idle", w, v);
    endtask

    task automatic t_illegal();
        logic [7:0] v, vt;
        do_req(4'd1, 8'hA5);
        wait_idle();
        do_read(4'd1, v, vt);
        chk(v[5] == 1'b1, "R7 error flag", v[5], 1);
        chk(v[7] == 1'b0, "R7 poll bit still inverted", v[7], 0);
        do_read(4'd0, v, vt);
        chk(v == 8'hFF, "R10 other address in error", v, 8'hFF);
        do_req(4'd12, 8'h00);
        chk(busy_n == 1'b1, "R3 request in error dropped", busy_n, 1);
        pulse_clr();
        do_read(4'd1, v, vt);
        chk(v == 8'h00, "R7 R11 byte is old AND new after clear", v, 8'h00);
        do_read(4'd12, v, vt);
        chk(v == 8'hFF, "R3 byte of dropped request", v, 8'hFF);
    endtask

    task automatic t_clr_idle();
        logic [7:0] v, vt;
        pulse_clr();
        chk(busy_n == 1'b1, "R11 clear when idle no busy", busy_n, 1);
        do_read(4'd8, v, vt);
        chk(v == 8'h3C, "R11 clear when idle no effect", v, 8'h3C);
    endtask

    task automatic t_timeout();
        logic [7:0] v, vt;
        int m;
        pulse_clr();
        do_req(4'd13, 8'h12);
        m = 0;
        while (!busy_n_to && m < 100) begin m++; @(negedge clk); end
        chk(m == TMO_SHORT, "R6 busy ends at timeout", m, TMO_SHORT);
        do_read(4'd13, v, vt);
        chk(vt[5] == 1'b1 && vt[7] == 1'b1, "R6 timeout status", vt & 8'hA0, 8'hA0);
        wait_idle();
        do_read(4'd13, v, vt);
        chk(v == 8'h12, "R5 long-timeout instance completes", v, 8'h12);
        pulse_clr();
        do_read(4'd13, v, vt);
        chk(vt == 8'hFF, "R6 array unchanged after timeout", vt, 8'hFF);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_protect();
        t_chipsel();
        t_busy_len();
        t_status();
        t_illegal();
        t_clr_idle();
        t_timeout();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule